// File: doc/BRIEF.md
# Configuration Register Access Sequencer

This block sits on the device side of an asynchronous SRAM-style memory port and owns a 16-bit configuration register. It watches the bus one completed cycle at a time. Each completed cycle arrives as a single-clock event carrying its address, its write data and whether it was a read or a write. From this stream the block recognises two ways of reaching the register.

The first way uses the sleep pin. Once the sleep pin falls, the next falling edge of the write strobe must come within a fixed nanosecond window, measured against a free-running nanosecond timer input. The write that completes after that edge then copies the low address bits into the register. The second way is a software pattern of four accesses to the highest address. Two reads and then a write open the pattern. A fourth access that is a write loads the register from the data bus. A fourth access that is a read returns the register in place of memory data.

The block flags the bus writes that belong to either path, so that the memory behind it leaves those locations untouched. It also keeps a sticky flag that records that a software load has taken place.

Top module: `cfg_seq_access`

## Requirements
- R1: After reset the register reads 0x0010, the software-loaded flag is 0, and no read return is requested.
- R2: A read, a read, a write and a write, all at address 0x7FFFF with the sleep pin high, load the register from data bits 7:0 with bit 3 forced to zero, and set the software-loaded flag. The flag then stays set until reset. Bits 15:8 of the register always read zero.
- R3: A read, a read, a write and a read, all at 0x7FFFF, assert the read-return output during the fourth access, with the read-data output equal to the register. The register and the software-loaded flag do not change.
- R4: A third consecutive read of 0x7FFFF cancels the pattern. Later accesses to 0x7FFFF, including a full four-access pattern, have no effect until a read of some other address has completed.
- R5: Outside the cancelled state, an access to any address other than 0x7FFFF, or a write in the first or second position, returns the detector to its start. The accesses that follow must then form a complete new pattern.
- R6: The memory-write inhibit output is high during the third and fourth writes of a pattern, and during any write completed while the sleep pin is low. It is low for ordinary writes.
- R7: A software load never clears register bit 4. The new bit 4 is the OR of the old bit 4 and data bit 4.
- R8: With the sleep pin low, a write-strobe fall that comes 10 to 500 ns after the sleep-pin fall arms the sleep path. The next completed write then loads address bits 7:0 into the register, with bit 3 and bits 15:8 zero. This path may clear bit 4.
- R9: A write-strobe fall earlier than 10 ns or later than 500 ns after the sleep-pin fall does not arm the sleep path. A read that completes while the path is armed does not load the register.
- R10: The register changes only on the clock edge that samples a completed write. A write-strobe fall by itself leaves the register unchanged.
- R11: The sleep-pin path still loads the register after the software-loaded flag has been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low |
| sleep_n | input | 1 | Sleep pin level, active low |
| time_ns | input | TW | Free-running nanosecond timer |
| we_fall | input | 1 | One-cycle strobe on a write-strobe falling edge |
| cyc_done | input | 1 | One-cycle strobe when a bus cycle completes |
| cyc_wr | input | 1 | Completed cycle was a write |
| cyc_addr | input | ADDR_W | Address of the completed cycle |
| cyc_wdata | input | 16 | Write data of the completed cycle |
| cfg_o | output | 16 | Configuration register value |
| rd_ret_o | output | 1 | Return the register instead of memory data |
| rd_data_o | output | 16 | Data to return on a register read |
| mem_wr_inhibit_o | output | 1 | Keep the current write out of the memory |
| sw_loaded_o | output | 1 | Sticky software-load flag |

## Verification
The software path is driven with its two complete patterns. These show that the kind of fourth access alone decides between load and return. It is also driven with near-miss patterns: a third read, a write in second position, and a foreign address in the middle. These separate the cancel state from a plain restart. The sleep path is driven with write-strobe delays just inside and just outside both ends of the window, and with an armed read followed by a write. These tell a timing decision apart from a completion decision. Data values with bit 3 and bit 4 set in different combinations expose the forced-zero and sticky-bit handling.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD1,
        SQ_RD2,
        SQ_WR3,
        SQ_HOLD
    } seq_st_e;

    localparam logic [15:0] CFG_KEEP  = 16'h00F7;
    localparam int          SLEEP_BIT = 4;

endpackage

// File: rtl/cfgseq_detect.sv
module cfgseq_detect
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic              cyc_done,
    input  logic              cyc_wr,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              seq_load,
    output logic              seq_read,
    output logic              seq_wr_hit
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        seq_st_e st;
    } det_t;

    det_t r_q, r_d;
    logic hit, at_top;

    always_comb begin
        r_d        = r_q;
        seq_load   = 1'b0;
        seq_read   = 1'b0;
        seq_wr_hit = 1'b0;
        hit        = cyc_done && sleep_n;
        at_top     = (cyc_addr == TOP_ADDR);
        if (hit) begin
            unique case (r_q.st)
                SQ_IDLE: r_d.st = (at_top && !cyc_wr) ? SQ_RD1 : SQ_IDLE;
                SQ_RD1:  r_d.st = (at_top && !cyc_wr) ? SQ_RD2 : SQ_IDLE;
                SQ_RD2: begin
                    if (!at_top) begin
                        r_d.st = SQ_IDLE;
                    end else if (cyc_wr) begin
                        r_d.st     = SQ_WR3;
                        seq_wr_hit = 1'b1;
                    end else begin
                        r_d.st = SQ_HOLD;
                    end
                end
                SQ_WR3: begin
                    r_d.st = SQ_IDLE;
                    if (at_top) begin
                        if (cyc_wr) begin
                            seq_load   = 1'b1;
                            seq_wr_hit = 1'b1;
                        end else begin
                            seq_read = 1'b1;
                        end
                    end
                end
                SQ_HOLD: r_d.st = (!at_top && !cyc_wr) ? SQ_IDLE : SQ_HOLD;
                default: r_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: SQ_IDLE};
        else        r_q <= r_d;
    end

endmodule

// File: rtl/cfgseq_zzwin.sv
module cfgseq_zzwin #(
    parameter int TW      = 16,
    parameter int WIN_MIN = 10,
    parameter int WIN_MAX = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_n,
    input  logic [TW-1:0] time_ns,
    input  logic          we_fall,
    input  logic          cyc_done,
    input  logic          cyc_wr,
    output logic          zz_load,
    output logic          zz_wr
);

    localparam logic [TW-1:0] LO = TW'(WIN_MIN);
    localparam logic [TW-1:0] HI = TW'(WIN_MAX);

    typedef struct packed {
        logic          sleep_q;
        logic          waiting;
        logic          armed;
        logic [TW-1:0] t0;
    } zz_t;

    zz_t r_q, r_d;
    logic [TW-1:0] delta;
    logic          fall;

    always_comb begin
        r_d         = r_q;
        r_d.sleep_q = sleep_n;
        delta       = time_ns - r_q.t0;
        fall        = r_q.sleep_q && !sleep_n;
        zz_wr       = cyc_done && cyc_wr && !sleep_n;
        zz_load     = zz_wr && r_q.armed;
        if (sleep_n) begin
            r_d.waiting = 1'b0;
            r_d.armed   = 1'b0;
        end else if (fall) begin
            r_d.t0      = time_ns;
            r_d.waiting = 1'b1;
            r_d.armed   = 1'b0;
        end else begin
            if (r_q.waiting) begin
                if (we_fall) begin
                    r_d.waiting = 1'b0;
                    r_d.armed   = (delta >= LO) && (delta <= HI);
                end else if (delta > HI) begin
                    r_d.waiting = 1'b0;
                end
            end
            if (zz_load) r_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sleep_q: 1'b1, waiting: 1'b0, armed: 1'b0, t0: '0};
        else        r_q <= r_d;
    end

endmodule

// File: rtl/cfg_seq_access.sv
module cfg_seq_access
    import cfgseq_pkg::*;
#(
    parameter int          ADDR_W    = 19,
    parameter int          TW        = 16,
    parameter int          WIN_MIN   = 10,
    parameter int          WIN_MAX   = 500,
    parameter logic [15:0] RESET_VAL = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic [TW-1:0]     time_ns,
    input  logic              we_fall,
    input  logic              cyc_done,
    input  logic              cyc_wr,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [15:0]       cyc_wdata,
    output logic [15:0]       cfg_o,
    output logic              rd_ret_o,
    output logic [15:0]       rd_data_o,
    output logic              mem_wr_inhibit_o,
    output logic              sw_loaded_o
);

    typedef struct packed {
        logic [15:0] cfg;
        logic        sw_flag;
    } top_t;

    top_t r_q, r_d;
    logic seq_load, seq_read, seq_wr_hit, zz_load, zz_wr;
    logic [15:0] sw_val;

    cfgseq_detect #(.ADDR_W(ADDR_W)) det_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_n    (sleep_n),
        .cyc_done   (cyc_done),
        .cyc_wr     (cyc_wr),
        .cyc_addr   (cyc_addr),
        .seq_load   (seq_load),
        .seq_read   (seq_read),
        .seq_wr_hit (seq_wr_hit)
    );

    cfgseq_zzwin #(.TW(TW), .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) zz_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_n  (sleep_n),
        .time_ns  (time_ns),
        .we_fall  (we_fall),
        .cyc_done (cyc_done),
        .cyc_wr   (cyc_wr),
        .zz_load  (zz_load),
        .zz_wr    (zz_wr)
    );

    always_comb begin
        r_d               = r_q;
        sw_val            = cyc_wdata & CFG_KEEP;
        sw_val[SLEEP_BIT] = cyc_wdata[SLEEP_BIT] | r_q.cfg[SLEEP_BIT];
        if (zz_load) begin
            r_d.cfg = cyc_addr[15:0] & CFG_KEEP;
        end else if (seq_load) begin
            r_d.cfg     = sw_val;
            r_d.sw_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cfg: RESET_VAL & CFG_KEEP, sw_flag: 1'b0};
        else        r_q <= r_d;
    end

    assign cfg_o            = r_q.cfg;
    assign rd_data_o        = r_q.cfg;
    assign rd_ret_o         = seq_read;
    assign mem_wr_inhibit_o = seq_wr_hit || zz_wr;
    assign sw_loaded_o      = r_q.sw_flag;

endmodule

// File: rtl/cfg_seq_access_chk.sv
module cfg_seq_access_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_n,
    input logic              cyc_done,
    input logic              cyc_wr,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [15:0]       cfg_o,
    input logic              rd_ret_o,
    input logic              mem_wr_inhibit_o,
    input logic              sw_loaded_o
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[15:8] == 8'h00) && !cfg_o[3]);

    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_loaded_o |=> sw_loaded_o);

    p_ret_only_top_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ret_o |-> (cyc_done && !cyc_wr && sleep_n && (&cyc_addr)));

    p_inhibit_only_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_inhibit_o |-> (cyc_done && cyc_wr));

    p_sw_keeps_sleep_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_o[4]) |-> !$past(sleep_n));

    p_cfg_moves_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(cyc_done && cyc_wr));

endmodule

bind cfg_seq_access cfg_seq_access_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .sleep_n          (sleep_n),
    .cyc_done         (cyc_done),
    .cyc_wr           (cyc_wr),
    .cyc_addr         (cyc_addr),
    .cfg_o            (cfg_o),
    .rd_ret_o         (rd_ret_o),
    .mem_wr_inhibit_o (mem_wr_inhibit_o),
    .sw_loaded_o      (sw_loaded_o)
);

// File: tb/cfg_seq_access_tb_top.sv
module cfg_seq_access_tb_top;

    localparam int CLK_NS = 10;
    localparam logic [18:0] TOP = 19'h7FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_n = 1'b1;
    logic [15:0] time_ns = '0;
    logic        we_fall = 1'b0;
    logic        cyc_done = 1'b0;
    logic        cyc_wr = 1'b0;
    logic [18:0] cyc_addr = '0;
    logic [15:0] cyc_wdata = '0;
    logic [15:0] cfg_o, rd_data_o;
    logic        rd_ret_o, mem_wr_inhibit_o, sw_loaded_o;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) time_ns <= time_ns + 16'd5;

    cfg_seq_access dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .time_ns(time_ns),
        .we_fall(we_fall), .cyc_done(cyc_done), .cyc_wr(cyc_wr),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .cfg_o(cfg_o),
        .rd_ret_o(rd_ret_o), .rd_data_o(rd_data_o),
        .mem_wr_inhibit_o(mem_wr_inhibit_o), .sw_loaded_o(sw_loaded_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [18:0] a, input logic [15:0] d,
                       output bit ret, output bit inh, output logic [15:0] rdat);
        @(negedge clk);
        cyc_done = 1'b1; cyc_wr = wr; cyc_addr = a; cyc_wdata = d;
        #1;
        ret = rd_ret_o; inh = mem_wr_inhibit_o; rdat = rd_data_o;
        @(negedge clk);
        cyc_done = 1'b0; cyc_wr = 1'b0;
    endtask

    task automatic sw_write(input logic [15:0] d, output bit inh3, output bit inh4);
        bit r; logic [15:0] x;
        bus(1'b0, TOP, 16'h0, r, inh3, x);
        bus(1'b0, TOP, 16'h0, r, inh3, x);
        bus(1'b1, TOP, 16'h0, r, inh3, x);
        bus(1'b1, TOP, d, r, inh4, x);
    endtask

    task automatic zz_arm(input int k);
        @(negedge clk); sleep_n = 1'b0;
        repeat (k) @(negedge clk);
        we_fall = 1'b1;
        @(negedge clk); we_fall = 1'b0;
    endtask

    task automatic zz_leave();
        @(negedge clk); sleep_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 cfg", cfg_o, 16'h0010);
        chk("R1 flag", {15'd0, sw_loaded_o}, 16'd0);
        chk("R1 ret", {15'd0, rd_ret_o}, 16'd0);
    endtask

    task automatic t_sw_read();
        bit r, i; logic [15:0] x;
        bus(1'b0, TOP, 16'h0, r, i, x);
        bus(1'b0, TOP, 16'h0, r, i, x);
        bus(1'b1, TOP, 16'h0, r, i, x);
        bus(1'b0, TOP, 16'h0, r, i, x);
        chk("R3 ret", {15'd0, r}, 16'd1);
        chk("R3 data", x, 16'h0010);
        chk("R3 flag", {15'd0, sw_loaded_o}, 16'd0);
        chk("R3 cfg", cfg_o, 16'h0010);
    endtask

    task automatic t_zz_path();
        bit r, i; logic [15:0] x;
        zz_arm(2);
        chk("R10 no change on strobe", cfg_o, 16'h0010);
        bus(1'b0, 19'h7FF2C, 16'h0, r, i, x);
        chk("R9 armed read", cfg_o, 16'h0010);
        bus(1'b1, 19'h7FF2C, 16'h0, r, i, x);
        chk("R8 inhibit", {15'd0, i}, 16'd1);
        chk("R8 load 10ns", cfg_o, 16'h0024);
        zz_leave();
        zz_arm(1);
        bus(1'b1, 19'h000FF, 16'h0, r, i, x);
        chk("R9 early", cfg_o, 16'h0024);
        zz_leave();
        zz_arm(101);
        bus(1'b1, 19'h000FF, 16'h0, r, i, x);
        chk("R9 late", cfg_o, 16'h0024);
        zz_leave();
        zz_arm(100);
        bus(1'b1, 19'h00081, 16'h0, r, i, x);
        chk("R8 load 500ns", cfg_o, 16'h0081);
        zz_leave();
    endtask

    task automatic t_sw_write();
        bit i3, i4, r, i; logic [15:0] x;
        bus(1'b1, 19'h00100, 16'h1234, r, i, x);
        chk("R6 plain write", {15'd0, i}, 16'd0);
        sw_write(16'hABCD, i3, i4);
        chk("R6 third", {15'd0, i3}, 16'd1);
        chk("R6 fourth", {15'd0, i4}, 16'd1);
        chk("R2 load", cfg_o, 16'h00C5);
        chk("R2 flag", {15'd0, sw_loaded_o}, 16'd1);
        sw_write(16'h0090, i3, i4);
        chk("R7 set", cfg_o, 16'h0090);
        sw_write(16'h0003, i3, i4);
        chk("R7 keep bit4", cfg_o, 16'h0013);
    endtask

    task automatic t_cancel();
        bit r, i, i3, i4; logic [15:0] x;
        bus(1'b0, TOP, 16'h0, r, i, x);
        bus(1'b0, TOP, 16'h0, r, i, x);
        bus(1'b0, TOP, 16'h0, r, i, x);
        sw_write(16'h0055, i3, i4);
        chk("R4 held", cfg_o, 16'h0013);
        chk("R4 no inhibit", {15'd0, i4}, 16'd0);
        bus(1'b0, 19'h00010, 16'h0, r, i, x);
        sw_write(16'h0055, i3, i4);
        chk("R4 released", cfg_o, 16'h0055);
    endtask

    task automatic t_restart();
        bit r, i; logic [15:0] x;
        bus(1'b0, TOP, 16'h0, r, i, x);
        bus(1'b0, 19'h00020, 16'h0, r, i, x);
        bus(1'b1, TOP, 16'h0, r, i, x);
        bus(1'b1, TOP, 16'h00AA, r, i, x);
        chk("R5 foreign addr", cfg_o, 16'h0055);
        bus(1'b0, TOP, 16'h0, r, i, x);
        bus(1'b1, TOP, 16'h0, r, i, x);
        bus(1'b0, TOP, 16'h0, r, i, x);
        bus(1'b1, TOP, 16'h00AA, r, i, x);
        chk("R5 early write", cfg_o, 16'h0055);
    endtask

    task automatic t_zz_after_sw();
        bit r, i; logic [15:0] x;
        zz_arm(3);
        bus(1'b1, 19'h00042, 16'h0, r, i, x);
        chk("R11 load", cfg_o, 16'h0042);
        chk("R11 flag", {15'd0, sw_loaded_o}, 16'd1);
        zz_leave();
    endtask

    initial begin
        #(CLK_NS * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_read();
        t_zz_path();
        t_sw_write();
        t_cancel();
        t_restart();
        t_zz_after_sw();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule